// File: doc/BRIEF.md
# Swappable Boot Memory Decoder

This block is the chip-select decoder for an 8-bit processor with a 16-bit address bus. For each address it picks one of five targets: two boot flash segments, one main flash segment, a 2 KB SRAM, or a 256-byte control register window. The selects are combinational from the address. The only state that steers them is one swap flag.

The swap flag is the top bit of an 8-bit volatile page register inside the register window. Firmware running from boot flash writes it to exchange the boot segments and the main flash segment between the 0x4000 and 0xC000 halves of the map. The main flash then answers at the reset vector without the processor doing anything else. The new map applies from the next access cycle, with no stall.

A boot-source strap pin is latched once after reset and can be read back. It never alters the page register; firmware copies it there if it wants the swap.

Top module: `swap_boot_decoder`

## Requirements
- R1: With the swap bit clear, boot segment 0 (sel_o bit 0) answers 0xC000–0xDFFF and boot segment 1 (sel_o bit 1) answers 0xE000–0xFFFF.
- R2: With the swap bit set, boot segment 0 answers 0x4000–0x5FFF and boot segment 1 answers 0x6000–0x7FFF.
- R3: The main flash select (sel_o bit 2) answers 0x4000–0x7FFF with the swap bit clear and 0xC000–0xFFFF with it set.
- R4: Two selects do not depend on the swap bit: the SRAM select (sel_o bit 3) answers 0xA000–0xA7FF, and the register window select (sel_o bit 4) answers 0xB000–0xB0FF.
- R5: The page register at 0xB0E0 stores all 8 written bits and reads them back unchanged. Bit 7 is the swap bit. Bits 6:0 have no effect on decoding.
- R6: Reset clears the page register to 0x00, so the swap bit is clear.
- R7: A write to 0xB0E0 takes effect at the clock edge where write enable is high. The selects follow the new swap bit in the very next cycle.
- R8: At most one sel_o bit is high. An address that matches no segment drives sel_o to 0, and a read from it returns 0xFF.
- R9: The strap pin is latched on the first clock after reset is released and reads back at 0xB0E2 in bit 0, with bits 7:1 zero. It never changes the page register. Later changes of the pin have no effect.
- R10: Read data is 0x00 whenever read enable is low. Inside a memory segment, and at register window offsets other than 0xE0 and 0xE2, read data is also 0x00.
- R11: A write to any address other than 0xB0E0 leaves the page register and the decode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Processor address |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 8 | Write data |
| boot_strap_i | input | 1 | Boot-source strap pin |
| sel_o | output | 5 | One-hot selects: boot0, boot1, main, sram, regs |
| rd_data_o | output | 8 | Read data from the register window or the unmapped-read value |

## Verification
The selects and the read data are combinational, so they are due in the same cycle as the address. The bench drives inputs just after the falling edge and compares against its model one nanosecond later, before the next rising edge.

A page register write takes effect at the rising edge where it is presented. The model applies the write at that edge, so the swap is checked in the following cycle, including a boot-vector access placed directly after the write.

The strap latch is also checked in the cycle after the first edge that follows reset release.

// File: rtl/swap_decode_pkg.sv
package swap_decode_pkg;
    localparam int unsigned SEL_BOOT0 = 0;
    localparam int unsigned SEL_BOOT1 = 1;
    localparam int unsigned SEL_MAIN  = 2;
    localparam int unsigned SEL_SRAM  = 3;
    localparam int unsigned SEL_REGS  = 4;
    localparam int unsigned SEL_N     = 5;

    typedef struct packed {
        logic [7:0] page;
        logic       strap;
        logic       armed;
    } ctl_state_t;
endpackage

// File: rtl/swap_addr_decode.sv
module swap_addr_decode
    import swap_decode_pkg::*;
#(
    parameter int unsigned HI_W       = 8,
    parameter int unsigned SRAM_SHIFT = 3,
    parameter logic [HI_W-1:0] SRAM_HI = 8'hA0,
    parameter logic [HI_W-1:0] REG_HI  = 8'hB0
) (
    input  logic [HI_W-1:0]  addr_hi_i,
    input  logic             swap_i,
    output logic [SEL_N-1:0] sel_o
);
    localparam logic [1:0] HALF_LO = 2'b01;
    localparam logic [1:0] HALF_HI = 2'b11;

    logic [1:0] half;
    logic       upper8k;
    logic       in_boot_half;
    logic       in_main_half;

    assign half         = addr_hi_i[HI_W-1:HI_W-2];
    assign upper8k      = addr_hi_i[HI_W-3];
    assign in_boot_half = swap_i ? (half == HALF_LO) : (half == HALF_HI);
    assign in_main_half = swap_i ? (half == HALF_HI) : (half == HALF_LO);

    always_comb begin
        sel_o            = '0;
        sel_o[SEL_BOOT0] = in_boot_half && !upper8k;
        sel_o[SEL_BOOT1] = in_boot_half &&  upper8k;
        sel_o[SEL_MAIN]  = in_main_half;
        sel_o[SEL_SRAM]  = (addr_hi_i[HI_W-1:SRAM_SHIFT] == SRAM_HI[HI_W-1:SRAM_SHIFT]);
        sel_o[SEL_REGS]  = (addr_hi_i == REG_HI);
    end
endmodule

// File: rtl/swap_page_reg.sv
module swap_page_reg
    import swap_decode_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_page_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              strap_i,
    output logic [DATA_W-1:0] page_o,
    output logic              strap_o
);
    ctl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.armed) begin
            st_d.strap = strap_i;
            st_d.armed = 1'b0;
        end
        if (wr_page_i) begin
            st_d.page = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{page: 8'h00, strap: 1'b0, armed: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign page_o  = st_q.page;
    assign strap_o = st_q.strap;
endmodule

// File: rtl/swap_read_mux.sv
module swap_read_mux
    import swap_decode_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter logic [7:0]  PAGE_OFS  = 8'hE0,
    parameter logic [7:0]  STRAP_OFS = 8'hE2
) (
    input  logic              rd_en_i,
    input  logic [7:0]        offset_i,
    input  logic [SEL_N-1:0]  sel_i,
    input  logic [DATA_W-1:0] page_i,
    input  logic              strap_i,
    output logic [DATA_W-1:0] rd_data_o
);
    always_comb begin
        rd_data_o = '0;
        if (rd_en_i) begin
            if (sel_i == '0) begin
                rd_data_o = '1;
            end else if (sel_i[SEL_REGS]) begin
                if (offset_i == PAGE_OFS) begin
                    rd_data_o = page_i;
                end else if (offset_i == STRAP_OFS) begin
                    rd_data_o = {{(DATA_W-1){1'b0}}, strap_i};
                end
            end
        end
    end
endmodule

// File: rtl/swap_boot_decoder.sv
module swap_boot_decoder
    import swap_decode_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned SRAM_BYTES = 2048,
    parameter logic [15:0] SRAM_BASE  = 16'hA000,
    parameter logic [15:0] REG_BASE   = 16'hB000,
    parameter logic [7:0]  PAGE_OFS   = 8'hE0,
    parameter logic [7:0]  STRAP_OFS  = 8'hE2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [15:0]       addr_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [7:0]        wdata_i,
    input  logic              boot_strap_i,
    output logic [4:0]        sel_o,
    output logic [7:0]        rd_data_o
);
    localparam int unsigned OFS_W      = 8;
    localparam int unsigned HI_W       = ADDR_W - OFS_W;
    localparam int unsigned SRAM_SHIFT = $clog2(SRAM_BYTES) - OFS_W;
    localparam int unsigned SWAP_BIT   = DATA_W - 1;

    logic [DATA_W-1:0] page_q;
    logic              strap_q;
    logic              wr_page;
    logic [SEL_N-1:0]  sel;

    assign wr_page = wr_en_i && (addr_i == {REG_BASE[ADDR_W-1:OFS_W], PAGE_OFS});

    swap_page_reg #(.DATA_W(DATA_W)) u_page (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_page_i (wr_page),
        .wdata_i   (wdata_i),
        .strap_i   (boot_strap_i),
        .page_o    (page_q),
        .strap_o   (strap_q)
    );

    swap_addr_decode #(
        .HI_W       (HI_W),
        .SRAM_SHIFT (SRAM_SHIFT),
        .SRAM_HI    (SRAM_BASE[ADDR_W-1:OFS_W]),
        .REG_HI     (REG_BASE[ADDR_W-1:OFS_W])
    ) u_dec (
        .addr_hi_i (addr_i[ADDR_W-1:OFS_W]),
        .swap_i    (page_q[SWAP_BIT]),
        .sel_o     (sel)
    );

    swap_read_mux #(
        .DATA_W    (DATA_W),
        .PAGE_OFS  (PAGE_OFS),
        .STRAP_OFS (STRAP_OFS)
    ) u_rd (
        .rd_en_i   (rd_en_i),
        .offset_i  (addr_i[OFS_W-1:0]),
        .sel_i     (sel),
        .page_i    (page_q),
        .strap_i   (strap_q),
        .rd_data_o (rd_data_o)
    );

    assign sel_o = sel;
endmodule

// File: rtl/swap_boot_decoder_chk.sv
module swap_boot_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] addr,
    input logic        rd_en,
    input logic        wr_en,
    input logic [7:0]  wdata,
    input logic [4:0]  sel,
    input logic [7:0]  rd_data,
    input logic [7:0]  page
);
    logic wr_page;
    assign wr_page = wr_en && (addr == 16'hB0E0);

    // R8: never two selects at once
    a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R8: unmapped reads return all ones
    a_r8_unmapped_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == 5'b0) |-> rd_data == 8'hFF);

    // R5, R7: a page write lands at the next edge
    a_r5_page_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_page |=> page == $past(wdata));

    // R11: other writes leave the page alone
    a_r11_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_page |=> $stable(page));

    // R1: swap clear puts boot flash on the high half
    a_r1_boot_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!page[7] && addr[15:14] == 2'b11) |-> (sel[0] || sel[1]));

    // R3: swap set puts main flash on the high half
    a_r3_main_high: assert property (@(posedge clk) disable iff (!rst_n)
        (page[7] && addr[15:14] == 2'b11) |-> sel[2]);
endmodule

bind swap_boot_decoder swap_boot_decoder_chk u_chk (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .addr    (addr_i),
    .rd_en   (rd_en_i),
    .wr_en   (wr_en_i),
    .wdata   (wdata_i),
    .sel     (sel_o),
    .rd_data (rd_data_o),
    .page    (page_q)
);

// File: tb/sim_swap_boot_decoder.sv
`timescale 1ns/1ps
module sim_swap_boot_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic        strap = 1'b1;
    logic [4:0]  sel;
    logic [7:0]  rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    int m_page  = 0;
    int m_strap = 0;
    bit m_armed = 1;

    always #2 clk = ~clk;

    swap_boot_decoder u0 (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_en_i(rd_en),
        .wr_en_i(wr_en), .wdata_i(wdata), .boot_strap_i(strap),
        .sel_o(sel), .rd_data_o(rd_data)
    );

    // model update at every rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_page = 0; m_strap = 0; m_armed = 1;
        end else begin
            if (m_armed) begin m_strap = strap; m_armed = 0; end
            if (wr_en && addr == 16'hB0E0) m_page = wdata;
        end
    end

    function automatic logic [4:0] exp_sel(input int a, input int pg);
        bit sw;
        logic [4:0] s;
        sw = (pg & 8'h80) != 0;
        s = 5'b0;
        if (a >= 16'hA000 && a <= 16'hA7FF) s[3] = 1;
        else if (a >= 16'hB000 && a <= 16'hB0FF) s[4] = 1;
        else if (a >= 16'h4000 && a <= 16'h7FFF) begin
            if (sw) s[(a < 16'h6000) ? 0 : 1] = 1; else s[2] = 1;
        end else if (a >= 16'hC000) begin
            if (sw) s[2] = 1; else s[(a < 16'hE000) ? 0 : 1] = 1;
        end
        return s;
    endfunction

    function automatic logic [7:0] exp_rd(input int a, input bit rd, input int pg, input int st);
        if (!rd) return 8'h00;
        if (exp_sel(a, pg) == 5'b0) return 8'hFF;
        if (a == 16'hB0E0) return pg[7:0];
        if (a == 16'hB0E2) return {7'b0, st[0]};
        return 8'h00;
    endfunction

    function automatic string tag_of(input int a, input int pg);
        bit sw;
        sw = (pg & 8'h80) != 0;
        if (a == 16'hB0E0) return "R5";
        if (a == 16'hB0E2) return "R9";
        if (a >= 16'hA000 && a <= 16'hB0FF) return "R4";
        if ((a >= 16'h4000 && a <= 16'h7FFF) || a >= 16'hC000) begin
            if (sw) return (a >= 16'hC000) ? "R3" : "R2";
            return (a >= 16'hC000) ? "R1" : "R3";
        end
        return "R8";
    endfunction

    task automatic compare(input string tag);
        logic [4:0] es;
        logic [7:0] er;
        es = exp_sel(addr, m_page);
        er = exp_rd(addr, rd_en, m_page, m_strap);
        checks++;
        if (sel !== es) begin
            fails++;
            $display("FAIL %s sel addr=%h actual=%b expected=%b", tag, addr, sel, es);
        end
        checks++;
        if (rd_data !== er) begin
            fails++;
            $display("FAIL %s rd_data addr=%h actual=%h expected=%h", tag, addr, rd_data, er);
        end
    endtask

    // one bus cycle: drive after falling edge, check before rising edge
    task automatic cyc(input logic [15:0] a, input bit r, input bit w, input logic [7:0] d, input string tag);
        @(negedge clk);
        addr = a; rd_en = r; wr_en = w; wdata = d;
        #1;
        compare((tag == "") ? tag_of(a, m_page) : tag);
    endtask

    task automatic sweep(input string tag);
        logic [15:0] pts [16] = '{16'h0000, 16'h3FFF, 16'h4000, 16'h5FFF,
                                  16'h6000, 16'h7FFF, 16'h8000, 16'h9FFF,
                                  16'hA000, 16'hA7FF, 16'hA800, 16'hB0FF,
                                  16'hB100, 16'hC000, 16'hDFFF, 16'hE000};
        for (int i = 0; i < 16; i++) cyc(pts[i], 1, 0, 8'h00, tag);
        cyc(16'hFFFF, 1, 0, 8'h00, tag);
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R6: reset state, PAGE reads 0x00 and boot flash sits high
        repeat (3) @(posedge clk);
        #1; addr = 16'hB0E0; rd_en = 1; #1;
        compare("R6");
        @(negedge clk); rst_n = 1;
        cyc(16'hB0E0, 1, 0, 8'h00, "R6");
        cyc(16'hFFFE, 1, 0, 8'h00, "R6");
        // R9: strap latched, PAGE untouched; later pin change ignored
        strap = 0;
        cyc(16'hB0E2, 1, 0, 8'h00, "R9");
        cyc(16'hB0E0, 1, 0, 8'h00, "R9");
        cyc(16'hC000, 1, 0, 8'h00, "R9");
        // R10: read strobe low gives zero
        cyc(16'hB0E0, 0, 0, 8'h00, "R10");
        cyc(16'h1234, 0, 0, 8'h00, "R10");
        cyc(16'hB055, 1, 0, 8'h00, "R10");
        sweep("");
        // R11: writes elsewhere ignored
        cyc(16'hB0E1, 0, 1, 8'h80, "R11");
        cyc(16'hC0E0, 0, 1, 8'h80, "R11");
        cyc(16'hB0E0, 1, 0, 8'h00, "R11");
        cyc(16'hC000, 1, 0, 8'h00, "R11");
        // R7: swap then immediately fetch from reset vector area
        cyc(16'hB0E0, 0, 1, 8'h80, "R7");
        cyc(16'hFFFE, 1, 0, 8'h00, "R7");
        cyc(16'h4000, 1, 0, 8'h00, "R7");
        sweep("");
        // R5: low bits stored but no decode effect
        cyc(16'hB0E0, 0, 1, 8'h7F, "R5");
        cyc(16'hB0E0, 1, 0, 8'h00, "R5");
        cyc(16'hC000, 1, 0, 8'h00, "R5");
        cyc(16'h6000, 1, 0, 8'h00, "R5");
        cyc(16'hB0E0, 0, 1, 8'hA5, "R5");
        cyc(16'hB0E0, 1, 0, 8'h00, "R5");
        cyc(16'hE000, 1, 0, 8'h00, "R5");
        // swap back
        cyc(16'hB0E0, 0, 1, 8'h00, "R7");
        cyc(16'hE000, 1, 0, 8'h00, "R7");
        // mixed traffic, PAGE writes biased in
        for (int i = 0; i < 400; i++) begin
            int unsigned rv;
            logic [15:0] a;
            rv = $urandom;
            a = rv[15:0];
            if (rv[19:17] == 3'd0) a = 16'hB0E0;
            cyc(a, rv[20], rv[21], rv[31:24], "");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule